// File: doc/BRIEF.md
# Result-Latency Scoreboard Interlock

This block sits at the issue point of an in-order pipeline. For every general-purpose register it keeps a countdown of how many cycles remain before the result last written to it can be read. An instruction at issue presents its class code, its destination and up to three source registers. The block holds it, through a stall output, while any source it actually reads still has a result on the way. Instructions that touch none of the busy registers pass without delay, so a long divide or a slow memory load can be hidden behind independent work.

The delay applied to a destination comes from a fixed per-class table. Short arithmetic results take a few cycles, while divide, square root and off-chip loads take tens of cycles. A fused multiply-add reads three operands, but the register file has only two read ports. The block therefore holds every multiply-add for one extra read cycle once its operands are available. A ready mask shows every register's state on every cycle.

Top module: `sb_interlock`

## Requirements
- R1: After reset every bit of the ready mask is 1 and the stall output is 0.
- R2: Arithmetic class codes and the stall cycles seen by a dependent instruction issued right behind them: 0 plain = 0, 1 branch = 0, 2 population count = 1, 3 integer multiply = 5, 4 integer divide/remainder = 33, 5 float add/multiply/convert = 5, 6 float multiply-accumulate = 5, 7 float multiply-add = 10, 8 float divide = 30, 9 float square root = 56, and codes 13 to 15 = 0.
- R3: Load class codes and their delays: 10 local scratch load = 2, 11 global on-chip load = 20, 12 off-chip DRAM load = 36.
- R4: An instruction stalls while any enabled source register, in any of slots 0, 1 or 2, is not ready. Issued right after a producer with delay D, it stalls exactly D cycles.
- R5: An instruction whose enabled sources are all ready issues with no stall while other registers still have results pending.
- R6: A class-7 instruction always stalls one extra cycle after its sources become ready, so with all sources ready it stalls exactly 1 cycle.
- R7: A new write to a register that still has a result pending restarts that register's countdown from the new instruction's delay, whether that delay is shorter or longer.
- R8: Register 0 is always ready and writes to it are ignored. A source slot whose enable bit is 0 never causes a stall.
- R9: The ready mask bit of a destination drops to 0 on the cycle after issue when the delay D is nonzero. It returns to 1 exactly D cycles after that first cycle.
- R10: An instruction that is stalled, or that is withdrawn before issue, leaves its destination's ready bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | An instruction is presented for issue |
| iss_class | input | 4 | Instruction class code (see R2, R3) |
| iss_dst | input | IDX_W (6) | Destination register index |
| iss_dst_en | input | 1 | The instruction writes a destination |
| iss_srcs | input | NSRC*IDX_W (18) | Source indices, slot 0 in the low bits |
| iss_src_en | input | NSRC (3) | Per-slot source read enable |
| iss_stall | output | 1 | Hold the presented instruction this cycle |
| reg_ready | output | NREGS (64) | Per-register result-ready mask |

## Verification
A countdown that is loaded wrongly, or that decrements at the wrong rate, shows up as a stall count off by one or more on the next dependent instruction. It also shows on the ready mask, whose bit changes one cycle early or late. A missed reload on a repeated write shows as the old, longer or shorter wait on the following consumer. A wrong multiply-add read flag shows on that same instruction, as an absent or doubled extra stall cycle. Because the mask is visible on every cycle, a bad per-register state can be seen at the ports within one cycle of the issue that caused it.

// File: rtl/sb_pkg.sv
package sb_pkg;

    typedef enum logic [3:0] {
        CLS_PLAIN   = 4'd0,
        CLS_BRANCH  = 4'd1,
        CLS_POPC    = 4'd2,
        CLS_IMUL    = 4'd3,
        CLS_IDIV    = 4'd4,
        CLS_FARITH  = 4'd5,
        CLS_FMAC    = 4'd6,
        CLS_FMADD   = 4'd7,
        CLS_FDIV    = 4'd8,
        CLS_FSQRT   = 4'd9,
        CLS_LD_LOC  = 4'd10,
        CLS_LD_GLB  = 4'd11,
        CLS_LD_EXT  = 4'd12
    } iclass_e;

    localparam int DLY_POPC   = 1;
    localparam int DLY_IMUL   = 5;
    localparam int DLY_IDIV   = 33;
    localparam int DLY_FARITH = 5;
    localparam int DLY_FMAC   = 5;
    localparam int DLY_FMADD  = 10;
    localparam int DLY_FDIV   = 30;
    localparam int DLY_FSQRT  = 56;
    localparam int DLY_LD_LOC = 2;
    localparam int DLY_LD_GLB = 20;
    localparam int DLY_LD_EXT = 36;

    localparam int MAX_DLY = DLY_FSQRT;
    localparam int CNT_W   = $clog2(MAX_DLY + 1);

    typedef logic [CNT_W-1:0] cnt_t;

endpackage

// File: rtl/sb_lat_table.sv
module sb_lat_table
    import sb_pkg::*;
(
    input  logic [3:0] cls,
    output cnt_t       dly
);

    always_comb begin
        unique case (cls)
            CLS_POPC:   dly = cnt_t'(DLY_POPC);
            CLS_IMUL:   dly = cnt_t'(DLY_IMUL);
            CLS_IDIV:   dly = cnt_t'(DLY_IDIV);
            CLS_FARITH: dly = cnt_t'(DLY_FARITH);
            CLS_FMAC:   dly = cnt_t'(DLY_FMAC);
            CLS_FMADD:  dly = cnt_t'(DLY_FMADD);
            CLS_FDIV:   dly = cnt_t'(DLY_FDIV);
            CLS_FSQRT:  dly = cnt_t'(DLY_FSQRT);
            CLS_LD_LOC: dly = cnt_t'(DLY_LD_LOC);
            CLS_LD_GLB: dly = cnt_t'(DLY_LD_GLB);
            CLS_LD_EXT: dly = cnt_t'(DLY_LD_EXT);
            default:    dly = '0;
        endcase
    end

endmodule

// File: rtl/sb_cnt_bank.sv
module sb_cnt_bank
    import sb_pkg::*;
#(
    parameter int NREGS = 64,
    localparam int IDX_W = $clog2(NREGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_en,
    input  logic [IDX_W-1:0] ld_idx,
    input  cnt_t             ld_val,
    output logic [NREGS-1:0] ready
);

    assign ready[0] = 1'b1;

    for (genvar g = 1; g < NREGS; g++) begin : g_reg
        cnt_t cnt_d, cnt_q;
        logic hit;

        always_comb begin
            hit   = ld_en && (ld_idx == IDX_W'(g));
            cnt_d = cnt_q;
            if (hit) begin
                cnt_d = ld_val;
            end else if (cnt_q != '0) begin
                cnt_d = cnt_q - 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_d;
            end
        end

        assign ready[g] = (cnt_q == '0);

        assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q <= cnt_t'(MAX_DLY));

        assert_countdown_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (!hit && cnt_q != '0) |=> (cnt_q == cnt_t'($past(cnt_q) - 1'b1)));

        assert_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
            hit |=> (cnt_q == $past(ld_val)));
    end

endmodule

// File: rtl/sb_hazard.sv
module sb_hazard #(
    parameter int NREGS = 64,
    parameter int NSRC  = 3,
    localparam int IDX_W = $clog2(NREGS)
) (
    input  logic [NREGS-1:0]      ready,
    input  logic [NSRC*IDX_W-1:0] srcs,
    input  logic [NSRC-1:0]       src_en,
    output logic                  hazard
);

    logic [NSRC-1:0] slot_busy;

    always_comb begin
        for (int k = 0; k < NSRC; k++) begin
            slot_busy[k] = src_en[k] && !ready[srcs[k*IDX_W +: IDX_W]];
        end
        hazard = |slot_busy;
    end

endmodule

// File: rtl/sb_interlock.sv
module sb_interlock
    import sb_pkg::*;
#(
    parameter int NREGS = 64,
    parameter int NSRC  = 3,
    localparam int IDX_W = $clog2(NREGS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  iss_valid,
    input  logic [3:0]            iss_class,
    input  logic [IDX_W-1:0]      iss_dst,
    input  logic                  iss_dst_en,
    input  logic [NSRC*IDX_W-1:0] iss_srcs,
    input  logic [NSRC-1:0]       iss_src_en,
    output logic                  iss_stall,
    output logic [NREGS-1:0]      reg_ready
);

    typedef struct packed {
        logic extra_rd_done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic hazard;
    logic is_fma;
    logic need_extra;
    logic fire;
    logic ld_en;
    cnt_t dly;

    sb_lat_table u_lat (
        .cls (iss_class),
        .dly (dly)
    );

    sb_hazard #(.NREGS(NREGS), .NSRC(NSRC)) u_haz (
        .ready  (reg_ready),
        .srcs   (iss_srcs),
        .src_en (iss_src_en),
        .hazard (hazard)
    );

    sb_cnt_bank #(.NREGS(NREGS)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld_en  (ld_en),
        .ld_idx (iss_dst),
        .ld_val (dly),
        .ready  (reg_ready)
    );

    always_comb begin
        ctl_d      = ctl_q;
        is_fma     = (iss_class == CLS_FMADD);
        need_extra = is_fma && !ctl_q.extra_rd_done;
        iss_stall  = iss_valid && (hazard || need_extra);
        fire       = iss_valid && !iss_stall;
        ld_en      = fire && iss_dst_en && (iss_dst != '0);

        if (iss_valid && !hazard && need_extra) begin
            ctl_d.extra_rd_done = 1'b1;
        end
        if (fire || !iss_valid) begin
            ctl_d.extra_rd_done = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assert_fma_extra_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !iss_stall && is_fma) |-> $past(iss_valid && iss_stall));

    assert_stall_needs_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        iss_stall |-> iss_valid);

endmodule

// File: tb/sb_interlock_test.sv
module sb_interlock_test;

    localparam int NREGS = 64;
    localparam int NSRC  = 3;
    localparam int IDX_W = 6;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  iss_valid = 1'b0;
    logic [3:0]            iss_class = '0;
    logic [IDX_W-1:0]      iss_dst = '0;
    logic                  iss_dst_en = 1'b0;
    logic [NSRC*IDX_W-1:0] iss_srcs = '0;
    logic [NSRC-1:0]       iss_src_en = '0;
    logic                  iss_stall;
    logic [NREGS-1:0]      reg_ready;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    sb_interlock #(.NREGS(NREGS), .NSRC(NSRC)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .iss_valid  (iss_valid),
        .iss_class  (iss_class),
        .iss_dst    (iss_dst),
        .iss_dst_en (iss_dst_en),
        .iss_srcs   (iss_srcs),
        .iss_src_en (iss_src_en),
        .iss_stall  (iss_stall),
        .reg_ready  (reg_ready)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish (actual %0d cycles, expected fewer)", cyc);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic issue(input logic [3:0] cls, input int dst, input logic den,
                         input int a, input int b, input int c,
                         input logic [2:0] en, output int stalls);
        iss_valid  = 1'b1;
        iss_class  = cls;
        iss_dst    = IDX_W'(dst);
        iss_dst_en = den;
        iss_srcs   = {IDX_W'(c), IDX_W'(b), IDX_W'(a)};
        iss_src_en = en;
        stalls = 0;
        #1;
        while (iss_stall && stalls < 300) begin
            stalls++;
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        iss_valid  = 1'b0;
        iss_dst_en = 1'b0;
        iss_src_en = '0;
    endtask

    task automatic drain();
        repeat (60) @(negedge clk);
    endtask

    task automatic t_reset();
        #1;
        check("R1 ready mask all ones", int'(reg_ready == '1), 1);
        check("R1 no stall", int'(iss_stall), 0);
    endtask

    task automatic t_lat(input logic [3:0] cls, input int exp, input string req);
        int s;
        issue(cls, 10, 1'b1, 0, 0, 0, 3'b000, s);
        issue(4'd0, 0, 1'b0, 10, 0, 0, 3'b001, s);
        check(req, s, exp);
        drain();
    endtask

    task automatic t_ready_mask();
        int s;
        issue(4'd4, 6, 1'b1, 0, 0, 0, 3'b000, s);
        #1;
        check("R9 bit low after issue", int'(reg_ready[6]), 0);
        repeat (32) @(negedge clk);
        #1;
        check("R9 bit still low at D-1", int'(reg_ready[6]), 0);
        @(negedge clk);
        #1;
        check("R9 bit high at D", int'(reg_ready[6]), 1);
        drain();
    endtask

    task automatic t_independent();
        int s;
        issue(4'd4, 20, 1'b1, 0, 0, 0, 3'b000, s);
        issue(4'd3, 23, 1'b1, 21, 22, 0, 3'b011, s);
        check("R5 independent issue no stall", s, 0);
        #1;
        check("R5 divide still pending", int'(reg_ready[20]), 0);
        drain();
    endtask

    task automatic t_fma();
        int s;
        issue(4'd7, 31, 1'b1, 1, 2, 3, 3'b111, s);
        check("R6 multiply-add extra read cycle", s, 1);
        drain();
        issue(4'd3, 30, 1'b1, 0, 0, 0, 3'b000, s);
        issue(4'd7, 32, 1'b1, 1, 2, 30, 3'b111, s);
        check("R4 R6 slot 2 hazard plus extra read", s, 6);
        drain();
    endtask

    task automatic t_waw();
        int s;
        issue(4'd4, 7, 1'b1, 0, 0, 0, 3'b000, s);
        issue(4'd3, 7, 1'b1, 0, 0, 0, 3'b000, s);
        check("R7 second writer no stall", s, 0);
        issue(4'd0, 0, 1'b0, 7, 0, 0, 3'b001, s);
        check("R7 reload shorter delay", s, 5);
        drain();
        issue(4'd3, 8, 1'b1, 0, 0, 0, 3'b000, s);
        issue(4'd4, 8, 1'b1, 0, 0, 0, 3'b000, s);
        issue(4'd0, 0, 1'b0, 0, 8, 0, 3'b010, s);
        check("R7 reload longer delay", s, 33);
        drain();
    endtask

    task automatic t_r0_and_disabled();
        int s;
        issue(4'd4, 0, 1'b1, 0, 0, 0, 3'b000, s);
        #1;
        check("R8 register 0 stays ready", int'(reg_ready[0]), 1);
        issue(4'd0, 0, 1'b0, 0, 0, 0, 3'b001, s);
        check("R8 read of register 0 no stall", s, 0);
        issue(4'd4, 11, 1'b1, 0, 0, 0, 3'b000, s);
        issue(4'd0, 0, 1'b0, 1, 11, 11, 3'b001, s);
        check("R8 disabled slots ignored", s, 0);
        drain();
    endtask

    task automatic t_stalled_no_effect();
        int s;
        issue(4'd4, 12, 1'b1, 0, 0, 0, 3'b000, s);
        iss_valid  = 1'b1;
        iss_class  = 4'd4;
        iss_dst    = IDX_W'(13);
        iss_dst_en = 1'b1;
        iss_srcs   = {IDX_W'(0), IDX_W'(0), IDX_W'(12)};
        iss_src_en = 3'b001;
        #1;
        check("R10 dependent is stalled", int'(iss_stall), 1);
        repeat (10) @(negedge clk);
        #1;
        check("R10 stalled dest untouched", int'(reg_ready[13]), 1);
        iss_valid  = 1'b0;
        iss_dst_en = 1'b0;
        iss_src_en = '0;
        @(negedge clk);
        #1;
        check("R10 withdrawn dest untouched", int'(reg_ready[13]), 1);
        drain();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();

        t_lat(4'd0,  0,  "R2 plain delay");
        t_lat(4'd1,  0,  "R2 branch delay");
        t_lat(4'd2,  1,  "R2 popcount delay");
        t_lat(4'd3,  5,  "R2 int multiply delay");
        t_lat(4'd4,  33, "R2 int divide delay");
        t_lat(4'd5,  5,  "R2 float arith delay");
        t_lat(4'd6,  5,  "R2 multiply-accumulate delay");
        t_lat(4'd7,  10, "R2 multiply-add delay");
        t_lat(4'd8,  30, "R2 float divide delay");
        t_lat(4'd9,  56, "R2 square root delay");
        t_lat(4'd14, 0,  "R2 unused code delay");
        t_lat(4'd10, 2,  "R3 local load delay");
        t_lat(4'd11, 20, "R3 global load delay");
        t_lat(4'd12, 36, "R3 DRAM load delay R4");

        t_ready_mask();
        t_independent();
        t_fma();
        t_waw();
        t_r0_and_disabled();
        t_stalled_no_effect();

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule